// File: doc/BRIEF.md
# Correlated Slip Channel Emulator

This block sits in a test path between a bit source and a synchronization decoder and damages a serial bit stream the way a patterned-media write channel does. A bit that is dropped or a spurious bit that is added is always followed later by the slip of the other kind, so the stream returns to alignment after each pair. Bit flips occur independently on every carried bit. All randomness comes from on-chip 16-bit shift-register generators. Every probability is a 16-bit unsigned threshold, so the probability is roughly threshold/65535.

Bits enter and leave on valid/ready handshakes, one bit per beat. While no pair is open, each input bit is either dropped, preceded by one random extra bit, or carried. Once a pair opens, the chance that the closing slip lands on the next bit starts at a programmable value and is multiplied by a Q0.16 ratio after every bit that does not close it. Each output beat carries a 2-bit tag so that a bench can rebuild the true alignment between sent and received bits.

Top module: `cid_chan`

## Requirements
- R1: After reset no beat is presented (out_valid low), no pair is open, and with all thresholds zero the input is accepted (in_ready high).
- R2: A 16-bit draw, which is never zero, fires when it is less than or equal to its threshold. A threshold of 0 therefore never fires and a threshold of 0xFFFF always fires.
- R3: With no pair open, an input bit is dropped if the drop draw fires (against thr_del). Otherwise, if the add draw fires (against thr_ins), an extra bit is added. Otherwise the bit is carried unchanged. A drop takes priority over an add.
- R4: An add presents one random beat tagged 1 ahead of the input bit. In that cycle in_ready is low, and the input bit follows as the next beat.
- R5: A drop opens a pair that can only be closed by an add, and an add opens a pair that can only be closed by a drop. While a pair is open, no slip of the opening kind occurs.
- R6: While a pair is open, the closing threshold is close_init for the first bit after the opening slip. After each bit that does not close the pair, the threshold becomes floor(threshold·decay_ratio/65536). A threshold of 0 keeps the pair open.
- R7: After the closing slip the base thresholds thr_del and thr_ins apply again, starting from the next input bit.
- R8: Every beat that carries an input bit is inverted when the flip draw fires (against thr_sub). Added beats are never flipped.
- R9: The tag codes are: 0 for a carried bit, 1 for an added beat, 2 for the first carried bit after a dropped bit that is not flipped, and 3 for a flipped bit. Code 3 takes precedence over code 2.
- R10: While out_valid is high and out_ready is low, the beat and its tag hold. No beat is lost or repeated under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit available |
| in_ready | output | 1 | Input bit taken this cycle |
| in_bit | input | 1 | Input data bit |
| thr_del | input | 16 | Drop threshold when unpaired |
| thr_ins | input | 16 | Add threshold when unpaired |
| thr_sub | input | 16 | Flip threshold for carried bits |
| close_init | input | 16 | Closing threshold at distance one |
| decay_ratio | input | 16 | Q0.16 ratio applied per non-closing bit |
| out_valid | output | 1 | Output beat available |
| out_ready | input | 1 | Output beat taken this cycle |
| out_bit | output | 1 | Output data bit |
| out_tag | output | 2 | Event code of the beat |

## Verification
A pair state stuck open or wrongly cleared changes the pattern of tags and lengths within one or two input bits when thresholds are set to 0 or 0xFFFF. The count of added beats against input bits then drifts away from the expected ratio. A closing threshold that decays incorrectly cannot be seen from any single beat. It appears only over hundreds of bits, as too many or too few pairs when decay_ratio is 0 or close to 1. A flip or tag fault appears on the very next beat.

// File: rtl/cid_pkg.sv
package cid_pkg;
  localparam int PROB_W = 16;
  typedef logic [PROB_W-1:0] prob_t;

  localparam int N_DRAW = 5;
  localparam int D_DEL  = 0;
  localparam int D_INS  = 1;
  localparam int D_CLS  = 2;
  localparam int D_SUB  = 3;
  localparam int D_BIT  = 4;

  localparam prob_t POLY_DEF = 16'hB400;

  typedef enum logic [1:0] {
    TAG_XMIT = 2'd0,
    TAG_INS  = 2'd1,
    TAG_DELF = 2'd2,
    TAG_SUB  = 2'd3
  } tag_e;

  typedef enum logic [1:0] {
    PAIR_NONE = 2'd0,
    PAIR_INS  = 2'd1,
    PAIR_DEL  = 2'd2
  } pair_e;

  // Galois shift step.
  function automatic prob_t lfsr_step(input prob_t s, input prob_t poly);
    return s[0] ? ((s >> 1) ^ poly) : (s >> 1);
  endfunction

  // An event fires when a nonzero draw is at or below the threshold.
  function automatic logic fires(input prob_t draw, input prob_t thr);
    return (draw != '0) && (draw <= thr);
  endfunction

  // Q0.16 scaling of the closing threshold, truncated.
  function automatic prob_t decay(input prob_t p, input prob_t r);
    logic [2*PROB_W-1:0] m;
    m = {{PROB_W{1'b0}}, p} * {{PROB_W{1'b0}}, r};
    return m[2*PROB_W-1:PROB_W];
  endfunction

  // Distinct nonzero start value per generator.
  function automatic prob_t seed_of(input int k);
    logic [31:0] t;
    t = 32'h0000ACE1 ^ (32'(k) * 32'h00001F35);
    return (t[PROB_W-1:0] == '0) ? prob_t'(1) : t[PROB_W-1:0];
  endfunction
endpackage

// File: rtl/cid_lfsr.sv
module cid_lfsr
  import cid_pkg::*;
#(
  parameter prob_t SEED = 16'h0001,
  parameter prob_t POLY = POLY_DEF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  output prob_t state
);
  prob_t s_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   s_q <= SEED;
    else if (adv) s_q <= lfsr_step(s_q, POLY);
  end

  assign state = s_q;
endmodule

// File: rtl/cid_pair_ctrl.sv
module cid_pair_ctrl
  import cid_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  decide,
  input  prob_t draw_del,
  input  prob_t draw_ins,
  input  prob_t draw_cls,
  input  prob_t thr_del,
  input  prob_t thr_ins,
  input  prob_t close_init,
  input  prob_t decay_ratio,
  output logic  ev_del,
  output logic  ev_ins,
  output pair_e pair_state,
  output prob_t close_prob
);
  pair_e st_q;
  prob_t prob_q;
  logic  hit_del, hit_ins, hit_cls;

  always_comb begin
    hit_del = fires(draw_del, thr_del);
    hit_ins = fires(draw_ins, thr_ins);
    hit_cls = fires(draw_cls, prob_q);
    ev_del  = 1'b0;
    ev_ins  = 1'b0;
    unique case (st_q)
      PAIR_NONE: begin
        ev_del = hit_del;
        ev_ins = !hit_del && hit_ins;
      end
      PAIR_INS: ev_del = hit_cls;
      PAIR_DEL: ev_ins = hit_cls;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= PAIR_NONE;
      prob_q <= '0;
    end else if (decide) begin
      if (st_q == PAIR_NONE) begin
        if (ev_del) begin
          st_q   <= PAIR_DEL;
          prob_q <= close_init;
        end else if (ev_ins) begin
          st_q   <= PAIR_INS;
          prob_q <= close_init;
        end
      end else if (hit_cls) begin
        st_q <= PAIR_NONE;
      end else begin
        prob_q <= decay(prob_q, decay_ratio);
      end
    end
  end

  assign pair_state = st_q;
  assign close_prob = prob_q;
endmodule

// File: rtl/cid_chan.sv
module cid_chan
  import cid_pkg::*;
#(
  parameter prob_t POLY = POLY_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic [PROB_W-1:0] thr_del,
  input  logic [PROB_W-1:0] thr_ins,
  input  logic [PROB_W-1:0] thr_sub,
  input  logic [PROB_W-1:0] close_init,
  input  logic [PROB_W-1:0] decay_ratio,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit,
  output logic [1:0]        out_tag
);
  prob_t             draw [N_DRAW];
  logic [N_DRAW-1:0] adv;

  for (genvar k = 0; k < N_DRAW; k++) begin : g_rng
    cid_lfsr #(.SEED(seed_of(k)), .POLY(POLY)) u_rng (
      .clk(clk), .rst_n(rst_n), .adv(adv[k]), .state(draw[k])
    );
  end

  logic  ov_q, ob_q, ins_pend_q, delf_q;
  tag_e  otag_q;
  logic  can_load, decide_w, ev_del_w, ev_ins_w;
  logic  load_data, load_ins, flip_w;
  pair_e pair_w;
  prob_t cprob_w;

  cid_pair_ctrl u_pair (
    .clk(clk), .rst_n(rst_n), .decide(decide_w),
    .draw_del(draw[D_DEL]), .draw_ins(draw[D_INS]), .draw_cls(draw[D_CLS]),
    .thr_del(thr_del), .thr_ins(thr_ins),
    .close_init(close_init), .decay_ratio(decay_ratio),
    .ev_del(ev_del_w), .ev_ins(ev_ins_w),
    .pair_state(pair_w), .close_prob(cprob_w)
  );

  always_comb begin
    can_load  = !ov_q || out_ready;
    decide_w  = in_valid && can_load && !ins_pend_q;
    load_ins  = decide_w && ev_ins_w;
    load_data = (decide_w && !ev_del_w && !ev_ins_w) ||
                (ins_pend_q && in_valid && can_load);
    in_ready  = can_load && (ins_pend_q || !ev_ins_w);
    flip_w    = fires(draw[D_SUB], thr_sub);
    adv          = '0;
    adv[D_DEL]   = decide_w;
    adv[D_INS]   = decide_w;
    adv[D_CLS]   = decide_w;
    adv[D_SUB]   = load_data;
    adv[D_BIT]   = load_ins;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q       <= 1'b0;
      ob_q       <= 1'b0;
      otag_q     <= TAG_XMIT;
      ins_pend_q <= 1'b0;
      delf_q     <= 1'b0;
    end else begin
      if (load_ins) begin
        ov_q       <= 1'b1;
        ob_q       <= ^draw[D_BIT];
        otag_q     <= TAG_INS;
        ins_pend_q <= 1'b1;
      end else if (load_data) begin
        ov_q       <= 1'b1;
        ob_q       <= in_bit ^ flip_w;
        otag_q     <= flip_w ? TAG_SUB : (delf_q ? TAG_DELF : TAG_XMIT);
        ins_pend_q <= 1'b0;
        delf_q     <= 1'b0;
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
      if (decide_w && ev_del_w) delf_q <= 1'b1;
    end
  end

  assign out_valid = ov_q;
  assign out_bit   = ob_q;
  assign out_tag   = otag_q;
endmodule

// File: rtl/cid_chan_chk.sv
module cid_chan_chk
  import cid_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_bit,
  input logic [1:0] out_tag,
  input logic       decide,
  input logic       ev_del,
  input logic       ev_ins,
  input pair_e      pair_state,
  input prob_t      close_prob
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_tag));

  assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    decide |-> !(ev_del && ev_ins));

  assert_no_second_ins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    decide && pair_state == PAIR_INS |-> !ev_ins);

  assert_no_second_del_R5: assert property (@(posedge clk) disable iff (!rst_n)
    decide && pair_state == PAIR_DEL |-> !ev_del);

  assert_decay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    decide && pair_state != PAIR_NONE && !ev_del && !ev_ins |=> close_prob <= $past(close_prob));

  assert_ins_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    decide && ev_ins |=> out_valid && out_tag == TAG_INS);
endmodule

bind cid_chan cid_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_tag(out_tag),
  .decide(decide_w), .ev_del(ev_del_w), .ev_ins(ev_ins_w),
  .pair_state(pair_w), .close_prob(cprob_w)
);

// File: tb/sim_cid_chan.sv
`timescale 1ns/1ps
module sim_cid_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_bit;
  logic [1:0]  out_tag;
  logic [15:0] thr_del = '0, thr_ins = '0, thr_sub = '0, close_init = '0, decay_ratio = '0;

  always #2.5 clk = ~clk;

  cid_chan u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .thr_del(thr_del), .thr_ins(thr_ins), .thr_sub(thr_sub),
    .close_init(close_init), .decay_ratio(decay_ratio),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_tag(out_tag)
  );

  int n_chk = 0, n_bad = 0;
  bit in_q [4096];
  bit ob [8192];
  int ot [8192];
  bit ex_b [8192];
  int ex_t [8192];
  bit ex_c [8192];
  int n_out, n_stall, n_ex;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [15:0] d, input logic [15:0] i, input logic [15:0] s,
                         input logic [15:0] a, input logic [15:0] r);
    thr_del = d; thr_ins = i; thr_sub = s; close_init = a; decay_ratio = r;
  endtask

  task automatic fill(input int n, input int seed);
    int x = seed;
    for (int k = 0; k < n; k++) begin
      x = x ^ (x << 7); x = x ^ (x >>> 9); x = x ^ (x << 8);
      in_q[k] = x[5];
    end
  endtask

  task automatic run(input int n, input bit bp);
    int idx = 0, idle = 0, cyc = 0;
    n_out = 0; n_stall = 0;
    while (idle < 4 && cyc < 20000) begin
      @(negedge clk);
      out_ready = bp ? ((cyc % 3) != 0) : 1'b1;
      in_valid  = (idx < n);
      in_bit    = (idx < n) ? in_q[idx] : 1'b0;
      #1;
      if (in_valid && !in_ready && out_ready) n_stall++;
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) begin
        ob[n_out] = out_bit; ot[n_out] = int'(out_tag); n_out++;
      end
      if (idx >= n && !out_valid) idle++;
      cyc++;
    end
    in_valid = 1'b0;
    check(idx == n, "R10", "inputs consumed", idx, n);
  endtask

  task automatic cmp_stream(input string req);
    int bad_b = 0, bad_t = 0;
    check(n_out == n_ex, req, "beat count", n_out, n_ex);
    for (int k = 0; k < n_ex && k < n_out; k++) begin
      if (ot[k] != ex_t[k]) bad_t++;
      if (ex_c[k] && ob[k] != ex_b[k]) bad_b++;
    end
    check(bad_t == 0, req, "tag mismatches", bad_t, 0);
    check(bad_b == 0, req, "bit mismatches", bad_b, 0);
  endtask

  task automatic push_ex(input bit b, input int t, input bit care);
    ex_b[n_ex] = b; ex_t[n_ex] = t; ex_c[n_ex] = care; n_ex++;
  endtask

  task automatic t_reset();
    set_cfg(0, 0, 0, 16'hFFFF, 0);
    do_reset();
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
  endtask

  // R2 zero thresholds never fire; R10 backpressure keeps stream intact
  task automatic t_clean();
    set_cfg(0, 0, 0, 16'hFFFF, 0);
    do_reset(); fill(64, 12345); run(64, 1'b1);
    n_ex = 0;
    for (int k = 0; k < 64; k++) push_ex(in_q[k], 0, 1'b1);
    cmp_stream("R2");
  endtask

  // R8 all carried bits flipped with tag 3
  task automatic t_sub_all();
    set_cfg(0, 0, 16'hFFFF, 16'hFFFF, 0);
    do_reset(); fill(48, 777); run(48, 1'b0);
    n_ex = 0;
    for (int k = 0; k < 48; k++) push_ex(!in_q[k], 3, 1'b1);
    cmp_stream("R8");
  endtask

  // R3/R4/R5/R7: add opens, drop closes at once, base rates resume
  task automatic t_ins_first(input bit sub);
    set_cfg(0, 16'hFFFF, sub ? 16'hFFFF : 16'h0, 16'hFFFF, 0);
    do_reset(); fill(40, 4242); run(40, 1'b0);
    n_ex = 0;
    for (int k = 0; k < 40; k += 2) begin
      push_ex(1'b0, 1, 1'b0);
      push_ex(in_q[k] ^ sub, sub ? 3 : ((k == 0) ? 0 : 2), 1'b1);
    end
    cmp_stream(sub ? "R9" : "R7");
    check(n_stall == 20, "R4", "in_ready low cycles", n_stall, 20);
  endtask

  // R3 drop wins over add; R5 closing slip is an add
  task automatic t_del_first();
    set_cfg(16'hFFFF, 16'hFFFF, 0, 16'hFFFF, 0);
    do_reset(); fill(40, 999); run(40, 1'b0);
    n_ex = 0;
    for (int k = 1; k < 40; k += 2) begin
      push_ex(1'b0, 1, 1'b0);
      push_ex(in_q[k], 2, 1'b1);
    end
    cmp_stream("R3");
  endtask

  // R5/R6: closing threshold 0 keeps pair open; no second slip of same kind
  task automatic t_stuck();
    set_cfg(16'hFFFF, 0, 0, 0, 16'hFFFF);
    do_reset(); fill(30, 31337); run(30, 1'b0);
    n_ex = 0;
    for (int k = 1; k < 30; k++) push_ex(in_q[k], (k == 1) ? 2 : 0, 1'b1);
    cmp_stream("R5");
    set_cfg(0, 16'hFFFF, 0, 0, 16'hFFFF);
    do_reset(); fill(30, 2718); run(30, 1'b0);
    n_ex = 0;
    push_ex(1'b0, 1, 1'b0);
    for (int k = 0; k < 30; k++) push_ex(in_q[k], 0, 1'b1);
    cmp_stream("R6");
  endtask

  function automatic int count_tag(input int t);
    int c = 0;
    for (int k = 0; k < n_out; k++) if (ot[k] == t) c++;
    return c;
  endfunction

  // R6: ratio 0 kills the closing chance, ratio near 1 keeps it near close_init
  task automatic t_decay();
    int c;
    set_cfg(0, 16'hFFFF, 0, 16'h8000, 16'h0000);
    do_reset(); fill(1500, 55); run(1500, 1'b0);
    c = count_tag(1);
    check(c >= 1 && c <= 30, "R6", "pairs with ratio 0", c, 2);
    set_cfg(0, 16'hFFFF, 0, 16'h8000, 16'hFFFF);
    do_reset(); fill(1500, 56); run(1500, 1'b0);
    c = count_tag(1);
    check(c >= 100, "R6", "pairs with ratio ~1", c, 500);
  endtask

  // R8 half-rate flips land near half the bits
  task automatic t_sub_rate();
    int c;
    set_cfg(0, 0, 16'h8000, 16'hFFFF, 0);
    do_reset(); fill(1000, 8080); run(1000, 1'b1);
    c = count_tag(3);
    check(c >= 350 && c <= 650, "R8", "flipped beats", c, 500);
  endtask

  initial begin
    t_reset();
    t_clean();
    t_sub_all();
    t_ins_first(1'b0);
    t_ins_first(1'b1);
    t_del_first();
    t_stuck();
    t_decay();
    t_sub_rate();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule